// File: doc/BRIEF.md
# Parallel Loop Iteration Issue Controller

This block sequences a hardware-vectorized loop. A loop-start word arms it. The word names an index register, a power-of-two index step, and a mask of registers that carry values from one loop step to the next. It also selects the group and the bank that the mask covers, and it says whether each iteration begins with a serial preamble. Once the loop is armed, the controller launches iterations one per clock. Each iteration carries its own index value and a wrapping lane tag. Issue stops when the next index would reach the latched trip limit, and the controller then raises a single-cycle completion pulse.

When the preamble flag is set, iterations still launch in order, but each one after the first waits for the end-of-preamble marker of the iteration before it. That marker carries a short backward offset, and the controller resolves the offset into the address of the loop top. When the loop-end marker arrives from a lane, the controller decides whether that lane branches back or is discarded. Only the lane holding the final iteration's tag continues. The execution lanes, the register file and memory sit outside this block.

Top module: `loop_issue_ctrl`

## Requirements
- R1: After a start, the first issued iteration has index 0, and every issued index is strictly below the trip limit latched at start.
- R2: Each issued index equals the previous one plus 2^k, where k is start_word[5:3].
- R3: Without a preamble, iterations issue on consecutive cycles starting the cycle after the start is accepted, with no gaps until the last one.
- R4: With every issue, issue_fwd_map holds the 8-bit mask start_word[13:6] placed at bits [8*g+7:8*g], where g is start_word[15:14], with zeros elsewhere. issue_fp carries start_word[16] and issue_reg carries start_word[2:0].
- R5: When start_word[17] is set, only the first iteration issues without waiting. Each later iteration issues in the cycle after a pre_end_valid pulse and not before, and issue_pre is high on these issues.
- R6: pre_target equals pre_end_pc plus the sign-extended pre_end_off, so a negative offset points back from the marker.
- R7: Issue stops once the next index would be at least the limit, and loop_done is high for exactly the cycle after the last issue. A limit of 0 issues nothing and pulses loop_done in the cycle after the start.
- R8: For a loop-end marker (end_valid with end_tag), end_return is high only when the loop has finished and end_tag equals the tag of its final iteration. In every other case end_kill is high, and the two are never high together.
- R9: The issue tag starts at 0 and increments by one per issue, wrapping modulo LANES.
- R10: start_valid is ignored unless the controller is idle, so a start during a running loop or during the completion cycle changes nothing.
- R11: abort, and the active-low reset, return the controller to idle by the next cycle. No further issue follows, no loop_done pulse follows, and the finished-loop state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| abort | input | 1 | Cancel any loop in flight |
| start_valid | input | 1 | Loop-start word present |
| start_word | input | 18 | Loop-start fields: reg[2:0], k[5:3], mask[13:6], group[15:14], fp[16], preamble[17] |
| trip_limit | input | IDX_W | Index bound, latched at start |
| pre_end_valid | input | 1 | End-of-preamble marker |
| pre_end_pc | input | PC_W | Address of the end-of-preamble marker |
| pre_end_off | input | OFF_W | Signed backward offset carried by the marker |
| end_valid | input | 1 | Loop-end marker from a lane |
| end_tag | input | TAG_W | Tag of the lane reaching the loop end |
| issue_valid | output | 1 | An iteration is issued this cycle |
| issue_tag | output | TAG_W | Lane tag of the issued iteration |
| issue_index | output | IDX_W | Index value of the issued iteration |
| issue_reg | output | 3 | Index register number |
| issue_fp | output | 1 | Mask applies to the floating-point bank |
| issue_fwd_map | output | 32 | Registers read as forwarding nodes |
| issue_pre | output | 1 | Loop runs with a serial preamble |
| pre_target | output | PC_W | Resolved loop-top address |
| end_return | output | 1 | The ending lane branches back |
| end_kill | output | 1 | The ending lane is discarded |
| loop_done | output | 1 | Single-cycle completion pulse |

## Verification
The bench builds the block with LANES = 4, IDX_W = 16, PC_W = 16 and OFF_W = 6. With four lanes, a five-iteration loop is enough to show the tag wrapping back to zero. With a 16-bit index, step exponents from 0 to 3 can be combined with small limits so that the final index lands either below the limit or exactly on it. The 6-bit offset holds a negative value, which checks the sign extension of the preamble back-pointer.

// File: rtl/loop_issue_pkg.sv
// Package: shared types for the loop issue controller.
// Assumes: the loop-start word is 18 bits with the field layout in lis_decode.
package loop_issue_pkg;

    localparam int WORD_W = 18;
    localparam int MAP_W  = 32;
    localparam int GRP_N  = 4;
    localparam int GRP_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } lis_state_e;

    typedef struct packed {
        logic       pre;
        logic       fp;
        logic [1:0] grp;
        logic [7:0] mask;
        logic [2:0] k;
        logic [2:0] reg_no;
    } lis_cfg_t;

endpackage

// File: rtl/lis_decode.sv
// Module: lis_decode
// Splits a latched loop-start word into its fields and expands the
// intermediate-register mask into a full 32-entry forwarding map.
// Assumes: word layout reg[2:0], k[5:3], mask[13:6], grp[15:14], fp[16], pre[17].
module lis_decode
    import loop_issue_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output lis_cfg_t          cfg,
    output logic [MAP_W-1:0]  fwd_map
);

    // Field extraction.
    always_comb begin
        cfg.reg_no = word[2:0];
        cfg.k      = word[5:3];
        cfg.mask   = word[13:6];
        cfg.grp    = word[15:14];
        cfg.fp     = word[16];
        cfg.pre    = word[17];
    end

    // One slice per register group; only the selected group gets the mask.
    for (genvar g = 0; g < GRP_N; g++) begin : g_slice
        assign fwd_map[g*GRP_W +: GRP_W] =
            (cfg.grp == g[1:0]) ? cfg.mask : '0;
    end

endmodule

// File: rtl/lis_index_gen.sv
// Module: lis_index_gen
// Holds the running index and lane tag, steps them per issue, and flags
// when the next index would reach the limit.
// Assumes: IDX_W >= 8 so that a step of 2^7 fits; LANES is a power of two.
module lis_index_gen #(
    parameter int IDX_W = 16,
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [2:0]       k,
    input  logic [IDX_W-1:0] limit,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag,
    output logic             last
);

    localparam int EXT_W = IDX_W + 1;

    logic [EXT_W-1:0] step_ext;
    logic [EXT_W-1:0] next_ext;

    // Next index computed one bit wider so a wrap can never look small.
    always_comb begin
        step_ext = EXT_W'(1) << k;
        next_ext = {1'b0, idx} + step_ext;
        last     = (next_ext >= {1'b0, limit});
    end

    // Index and tag registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx <= '0;
            tag <= '0;
        end else if (advance) begin
            idx <= next_ext[IDX_W-1:0];
            tag <= tag + 1'b1;
        end
    end

endmodule

// File: rtl/lis_lane_retire.sv
// Module: lis_lane_retire
// Remembers the tag of the final iteration of the finished loop and
// classifies each loop-end marker as branch-back or discard.
// Assumes: markers arriving before the loop finishes are all discarded.
module lis_lane_retire #(
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             mark_last,
    input  logic [TAG_W-1:0] cur_tag,
    input  logic             end_valid,
    input  logic [TAG_W-1:0] end_tag,
    output logic             end_return,
    output logic             end_kill
);

    logic             have_last;
    logic [TAG_W-1:0] last_tag;

    // Capture the final lane of a finished loop.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            have_last <= 1'b0;
            last_tag  <= '0;
        end else if (mark_last) begin
            have_last <= 1'b1;
            last_tag  <= cur_tag;
        end
    end

    // Marker classification.
    always_comb begin
        end_return = end_valid && have_last && (end_tag == last_tag);
        end_kill   = end_valid && !end_return;
    end

endmodule

// File: rtl/loop_issue_ctrl.sv
// Module: loop_issue_ctrl (top)
// Accepts a loop-start word while idle, then issues one iteration per
// cycle (or one per preamble completion) until the trip limit, pulses
// loop_done, and classifies loop-end markers per lane.
// Assumes: LANES is a power of two and at least 2; reset is synchronous.
module loop_issue_ctrl
    import loop_issue_pkg::*;
#(
    parameter int LANES = 4,
    parameter int IDX_W = 16,
    parameter int PC_W  = 16,
    parameter int OFF_W = 6,
    localparam int TAG_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start_valid,
    input  logic [17:0]       start_word,
    input  logic [IDX_W-1:0]  trip_limit,
    input  logic              pre_end_valid,
    input  logic [PC_W-1:0]   pre_end_pc,
    input  logic [OFF_W-1:0]  pre_end_off,
    input  logic              end_valid,
    input  logic [TAG_W-1:0]  end_tag,
    output logic              issue_valid,
    output logic [TAG_W-1:0]  issue_tag,
    output logic [IDX_W-1:0]  issue_index,
    output logic [2:0]        issue_reg,
    output logic              issue_fp,
    output logic [31:0]       issue_fwd_map,
    output logic              issue_pre,
    output logic [PC_W-1:0]   pre_target,
    output logic              end_return,
    output logic              end_kill,
    output logic              loop_done
);

    lis_state_e        state;
    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  limit_q;
    logic              gate_q;
    lis_cfg_t          cfg;
    logic [2:0]        cfg_k;
    logic              cfg_pre;
    logic              accept;
    logic              fire;
    logic              last;

    // Start acceptance and issue firing.
    always_comb begin
        accept  = (state == ST_IDLE) && start_valid && !abort;
        fire    = (state == ST_RUN) && gate_q;
        cfg_k   = cfg.k;
        cfg_pre = cfg.pre;
    end

    // Control state machine.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (accept) state <= (trip_limit == '0) ? ST_DONE : ST_RUN;
                ST_RUN:  if (fire && last) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Latch the loop-start word and limit on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            limit_q <= '0;
        end else if (accept) begin
            word_q  <= start_word;
            limit_q <= trip_limit;
        end
    end

    // Issue gate: closed after each issue in preamble mode, reopened by a marker.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            gate_q <= 1'b0;
        end else if (accept) begin
            gate_q <= 1'b1;
        end else if (pre_end_valid && state == ST_RUN) begin
            gate_q <= 1'b1;
        end else if (fire && cfg.pre) begin
            gate_q <= 1'b0;
        end
    end

    lis_decode u_decode (
        .word    (word_q),
        .cfg     (cfg),
        .fwd_map (issue_fwd_map)
    );

    lis_index_gen #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept || abort),
        .advance (fire),
        .k       (cfg.k),
        .limit   (limit_q),
        .idx     (issue_index),
        .tag     (issue_tag),
        .last    (last)
    );

    lis_lane_retire #(
        .TAG_W (TAG_W)
    ) u_retire (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept || abort),
        .mark_last  (fire && last),
        .cur_tag    (issue_tag),
        .end_valid  (end_valid),
        .end_tag    (end_tag),
        .end_return (end_return),
        .end_kill   (end_kill)
    );

    // Issue-side outputs and the loop-top address.
    always_comb begin
        issue_valid = fire;
        issue_reg   = cfg.reg_no;
        issue_fp    = cfg.fp;
        issue_pre   = cfg.pre;
        loop_done   = (state == ST_DONE);
        pre_target  = pre_end_pc + {{(PC_W-OFF_W){pre_end_off[OFF_W-1]}}, pre_end_off};
    end

endmodule

// File: rtl/loop_issue_ctrl_chk.sv
// Module: loop_issue_ctrl_chk
// Temporal properties of the issue controller, attached by bind.
// Assumes: sampled on the controller clock; disabled while reset is low.
module loop_issue_ctrl_chk #(
    parameter int IDX_W = 16,
    parameter int TAG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             abort,
    input logic             issue_valid,
    input logic [TAG_W-1:0] issue_tag,
    input logic [IDX_W-1:0] issue_index,
    input logic [IDX_W-1:0] limit_q,
    input logic [2:0]       cfg_k,
    input logic             cfg_pre,
    input logic             loop_done,
    input logic             end_valid,
    input logic             end_return,
    input logic             end_kill
);

    // R1
    idx_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> issue_index < limit_q);

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && $past(issue_valid) |->
            issue_index == IDX_W'($past(issue_index) + (IDX_W'(1) << cfg_k)));

    // R3
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !cfg_pre && !abort |=> issue_valid || loop_done);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done |=> !loop_done);

    // R7
    done_not_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(loop_done && issue_valid));

    // R8
    end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(end_return && end_kill));

    // R8
    end_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_valid |-> end_return || end_kill);

    // R9
    tag_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && $past(issue_valid) |-> issue_tag == TAG_W'($past(issue_tag) + 1'b1));

    // R11
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !issue_valid && !loop_done);

endmodule

bind loop_issue_ctrl loop_issue_ctrl_chk #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .abort       (abort),
    .issue_valid (issue_valid),
    .issue_tag   (issue_tag),
    .issue_index (issue_index),
    .limit_q     (limit_q),
    .cfg_k       (cfg_k),
    .cfg_pre     (cfg_pre),
    .loop_done   (loop_done),
    .end_valid   (end_valid),
    .end_return  (end_return),
    .end_kill    (end_kill)
);

// File: tb/loop_issue_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module loop_issue_ctrl_tb;

    localparam int LANES = 4;
    localparam int IDX_W = 16;
    localparam int PC_W  = 16;
    localparam int OFF_W = 6;
    localparam int TAG_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              abort = 1'b0;
    logic              start_valid = 1'b0;
    logic [17:0]       start_word = '0;
    logic [IDX_W-1:0]  trip_limit = '0;
    logic              pre_end_valid = 1'b0;
    logic [PC_W-1:0]   pre_end_pc = '0;
    logic [OFF_W-1:0]  pre_end_off = '0;
    logic              end_valid = 1'b0;
    logic [TAG_W-1:0]  end_tag = '0;
    logic              issue_valid;
    logic [TAG_W-1:0]  issue_tag;
    logic [IDX_W-1:0]  issue_index;
    logic [2:0]        issue_reg;
    logic              issue_fp;
    logic [31:0]       issue_fwd_map;
    logic              issue_pre;
    logic [PC_W-1:0]   pre_target;
    logic              end_return;
    logic              end_kill;
    logic              loop_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    loop_issue_ctrl #(
        .LANES (LANES),
        .IDX_W (IDX_W),
        .PC_W  (PC_W),
        .OFF_W (OFF_W)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .abort         (abort),
        .start_valid   (start_valid),
        .start_word    (start_word),
        .trip_limit    (trip_limit),
        .pre_end_valid (pre_end_valid),
        .pre_end_pc    (pre_end_pc),
        .pre_end_off   (pre_end_off),
        .end_valid     (end_valid),
        .end_tag       (end_tag),
        .issue_valid   (issue_valid),
        .issue_tag     (issue_tag),
        .issue_index   (issue_index),
        .issue_reg     (issue_reg),
        .issue_fp      (issue_fp),
        .issue_fwd_map (issue_fwd_map),
        .issue_pre     (issue_pre),
        .pre_target    (pre_target),
        .end_return    (end_return),
        .end_kill      (end_kill),
        .loop_done     (loop_done)
    );

    function automatic logic [17:0] mk_word(input logic pre, input logic fp,
                                            input logic [1:0] grp, input logic [7:0] mask,
                                            input logic [2:0] k, input logic [2:0] rn);
        return {pre, fp, grp, mask, k, rn};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic start_loop(input logic [17:0] w, input logic [IDX_W-1:0] lim);
        start_word  = w;
        trip_limit  = lim;
        start_valid = 1'b1;
        tick();
        start_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk(issue_valid == 1'b0, "R11 reset issue", issue_valid, 0);
        chk(loop_done == 1'b0, "R11 reset done", loop_done, 0);
    endtask

    // Step 1, limit 5: tags wrap, start ignored while running, markers killed mid-run.
    task automatic t_basic();
        start_loop(mk_word(1'b0, 1'b1, 2'd2, 8'hA5, 3'd0, 3'd5), 16'd5);
        for (int i = 0; i < 5; i++) begin
            chk(issue_valid == 1'b1, "R3 issue valid", issue_valid, 1);
            chk(issue_index == IDX_W'(i), "R1 R2 index", issue_index, i);
            chk(issue_tag == TAG_W'(i % LANES), "R9 tag", issue_tag, i % LANES);
            if (i == 0) begin
                chk(issue_fwd_map == 32'h00A5_0000, "R4 map", issue_fwd_map, 32'h00A5_0000);
                chk(issue_fp == 1'b1 && issue_reg == 3'd5, "R4 fp/reg",
                    {issue_fp, issue_reg}, {1'b1, 3'd5});
                end_valid = 1'b1;
                end_tag   = 2'd0;
                #1;
                chk(end_kill == 1'b1 && end_return == 1'b0, "R8 mid-run kill",
                    {end_return, end_kill}, 2'b01);
                end_valid = 1'b0;
            end
            start_valid = (i == 1);
            start_word  = mk_word(1'b0, 1'b0, 2'd0, 8'hFF, 3'd3, 3'd1);
            tick();
        end
        start_valid = 1'b0;
        chk(loop_done == 1'b1 && issue_valid == 1'b0, "R7 done pulse",
            {loop_done, issue_valid}, 2'b10);
        start_valid = 1'b1;
        tick();
        start_valid = 1'b0;
        chk(loop_done == 1'b0, "R7 done single", loop_done, 0);
        tick();
        chk(issue_valid == 1'b0 && loop_done == 1'b0, "R10 start in done ignored",
            {issue_valid, loop_done}, 0);
    endtask

    // Step 8, limit 20: 0, 8, 16; then lane retirement.
    task automatic t_stride_and_end();
        start_loop(mk_word(1'b0, 1'b0, 2'd0, 8'h3C, 3'd3, 3'd2), 16'd20);
        for (int i = 0; i < 3; i++) begin
            chk(issue_valid && issue_index == IDX_W'(8 * i), "R2 stride 8", issue_index, 8 * i);
            if (i == 0)
                chk(issue_fwd_map == 32'h0000_003C, "R4 map group0", issue_fwd_map, 32'h3C);
            tick();
        end
        chk(loop_done == 1'b1, "R7 stop below limit", loop_done, 1);
        tick();
        end_valid = 1'b1;
        end_tag   = 2'd2;
        #1;
        chk(end_return == 1'b1 && end_kill == 1'b0, "R8 last lane returns",
            {end_return, end_kill}, 2'b10);
        end_tag = 2'd1;
        #1;
        chk(end_return == 1'b0 && end_kill == 1'b1, "R8 other lane killed",
            {end_return, end_kill}, 2'b01);
        end_valid = 1'b0;
    endtask

    // Step 4, limit 8: index 8 equals the limit and is not issued.
    task automatic t_exact_limit();
        start_loop(mk_word(1'b0, 1'b0, 2'd3, 8'h01, 3'd2, 3'd0), 16'd8);
        chk(issue_valid && issue_index == 16'd0, "R1 first index", issue_index, 0);
        chk(issue_fwd_map == 32'h0100_0000, "R4 map group3", issue_fwd_map, 32'h0100_0000);
        tick();
        chk(issue_valid && issue_index == 16'd4, "R2 step 4", issue_index, 4);
        tick();
        chk(!issue_valid && loop_done, "R7 limit reached", {issue_valid, loop_done}, 2'b01);
        tick();
    endtask

    task automatic t_zero_limit();
        start_loop(mk_word(1'b0, 1'b0, 2'd0, 8'h00, 3'd0, 3'd0), 16'd0);
        chk(!issue_valid && loop_done, "R7 zero limit", {issue_valid, loop_done}, 2'b01);
        tick();
        chk(!loop_done && !issue_valid, "R7 zero limit idle", {issue_valid, loop_done}, 0);
    endtask

    // Preamble mode, step 2, limit 6.
    task automatic t_preamble();
        start_loop(mk_word(1'b1, 1'b0, 2'd1, 8'h80, 3'd1, 3'd3), 16'd6);
        chk(issue_valid && issue_index == 16'd0 && issue_pre, "R5 first no wait",
            {issue_valid, issue_index}, {1'b1, 16'd0});
        tick();
        chk(!issue_valid, "R5 waits", issue_valid, 0);
        tick();
        chk(!issue_valid, "R5 still waits", issue_valid, 0);
        pre_end_valid = 1'b1;
        pre_end_pc    = 16'd100;
        pre_end_off   = 6'b111011;
        #1;
        chk(pre_target == 16'd95, "R6 back offset", pre_target, 95);
        tick();
        pre_end_valid = 1'b0;
        chk(issue_valid && issue_index == 16'd2, "R5 after marker", issue_index, 2);
        tick();
        chk(!issue_valid, "R5 gate closed", issue_valid, 0);
        pre_end_valid = 1'b1;
        tick();
        pre_end_valid = 1'b0;
        chk(issue_valid && issue_index == 16'd4, "R5 third", issue_index, 4);
        tick();
        chk(loop_done == 1'b1, "R7 preamble done", loop_done, 1);
        tick();
    endtask

    task automatic t_abort();
        start_loop(mk_word(1'b0, 1'b0, 2'd0, 8'h00, 3'd0, 3'd0), 16'd100);
        tick();
        tick();
        chk(issue_valid && issue_index == 16'd2, "R3 before abort", issue_index, 2);
        abort = 1'b1;
        tick();
        abort = 1'b0;
        chk(!issue_valid && !loop_done, "R11 abort stops", {issue_valid, loop_done}, 0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(!issue_valid && !loop_done, "R11 stays idle", {issue_valid, loop_done}, 0);
        end
        end_valid = 1'b1;
        end_tag   = 2'd0;
        #1;
        chk(end_kill && !end_return, "R11 finished state cleared",
            {end_return, end_kill}, 2'b01);
        end_valid = 1'b0;
    endtask

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_basic();
        t_stride_and_end();
        t_exact_limit();
        t_zero_limit();
        t_preamble();
        t_abort();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule